// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block keeps the single atomic-access reservation of one processor core. A load-and-reserve request forms an effective address from a base operand and an index operand, records the 32-byte block that address falls in, and raises a reservation flag. A later store-conditional request forms its own effective address and decides whether the word store goes to memory. The outcome is reported as a 4-bit condition nibble that also carries the summary-overflow bit.

A snoop port reports stores made by other bus masters. A snooped store that falls in the reserved block, while the flag is set, drops the reservation. Every store-conditional drops the reservation as well, whatever address it names. One cycle after a store-conditional request, the block gives out the registered result: a single-cycle write strobe with its address and data, and a valid pulse on the condition nibble. The core's pipeline uses the nibble to branch on success. The memory itself, address translation and the instruction decoder are outside the block.

Top module: `resv_monitor`

## Requirements
- R1: The effective address is (base + index) modulo 2^32. The base counts as zero when its register selector `ra_sel` is 0. On a store that goes ahead, `wr_addr` is this sum for the store-conditional.
- R2: After reset the reservation flag is clear, and `wr_en` and `cr_valid` are 0.
- R3: A load-and-reserve sets the flag and records the block, which is address bits [31:5]. A later store-conditional whose address is in the same block gives `wr_en`=1, `wr_data`=`rs_data`, and `cr_field` = {2'b00, 1, so_in}. Bit 1 of `cr_field` is the success bit and bit 0 is the summary-overflow copy.
- R4: A store-conditional made while the flag is clear gives no write (`wr_en`=0) and `cr_field` = {2'b00, 0, so_in}.
- R5: Every store-conditional clears the flag, so a second one that follows with no load-and-reserve between them fails.
- R6: With the flag set and the address in a different block, the outcome follows the parameter `MISMATCH_OK`. With the default value 0 the store does not happen and the nibble reports failure. The flag is cleared in either case.
- R7: A snooped store whose address is in the reserved block clears a set flag. A snooped store to any other block leaves the flag alone.
- R8: When a killing snoop and a store-conditional arrive in the same cycle, the snoop is applied first and the store-conditional fails.
- R9: A load-and-reserve made while a reservation is held replaces the recorded block and keeps the flag set.
- R10: `cr_valid` is a one-cycle pulse in the cycle after each store-conditional request. `wr_en` is high only in such a cycle, and only when the success bit is 1.
- R11: A load-and-reserve request in the same cycle as a store-conditional request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lr_req | input | 1 | Load-and-reserve request |
| sc_req | input | 1 | Store-conditional request |
| ra_sel | input | 5 | Base register selector; 0 means the base is zero |
| ra_val | input | 32 | Base operand value |
| rb_val | input | 32 | Index operand value |
| rs_data | input | 32 | Word that a store-conditional would store |
| so_in | input | 1 | Summary-overflow bit copied into the nibble |
| snoop_valid | input | 1 | Another master's store is observed |
| snoop_addr | input | 32 | Address of the observed store |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 32 | Memory write address |
| wr_data | output | 32 | Memory write data |
| cr_valid | output | 1 | Condition nibble valid |
| cr_field | output | 4 | Condition nibble {2'b00, success, so} |

## Verification
The hardest case to reach is a snoop kill that lands in the same cycle as a store-conditional to the reserved block. From the outside that store looks exactly like one that should succeed, and only the ordering rule makes it fail. The bench drives one cycle with `snoop_valid`, `sc_req` and matching addresses all together, straight after a load-and-reserve. It also drives a snoop to a different block before a store, so the bench can tell a real kill apart from a kill that fires on any snoop.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef enum logic [1:0] {
    SC_IDLE  = 2'd0,
    SC_FAIL  = 2'd1,
    SC_STORE = 2'd2
  } sc_outcome_e;

  function automatic logic [3:0] cr_pack(input logic success, input logic so);
    cr_pack = {2'b00, success, so};
  endfunction

endpackage

// File: rtl/resv_agen.sv
module resv_agen #(
  parameter int AW    = 32,
  parameter int SEL_W = 5
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [AW-1:0]    base,
  input  logic [AW-1:0]    index,
  output logic [AW-1:0]    ea
);

  function automatic logic [AW-1:0] form_ea(input logic [SEL_W-1:0] s,
                                            input logic [AW-1:0] b,
                                            input logic [AW-1:0] x);
    logic [AW-1:0] eff_base;
    eff_base = (s == '0) ? '0 : b;
    form_ea  = eff_base + x;
  endfunction

  assign ea = form_ea(sel, base, index);

endmodule

// File: rtl/resv_track.sv
module resv_track #(
  parameter int AW       = 32,
  parameter int GRAN_LG2 = 5,
  localparam int BLK_W   = AW - GRAN_LG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lr_fire,
  input  logic             sc_fire,
  input  logic [AW-1:0]    lr_addr,
  input  logic             snoop_valid,
  input  logic [AW-1:0]    snoop_addr,
  output logic             flag,
  output logic [BLK_W-1:0] blk,
  output logic             snoop_kill,
  output logic             flag_eff
);

  logic [BLK_W-1:0] snoop_blk;

  assign snoop_blk  = snoop_addr[AW-1:GRAN_LG2];
  assign snoop_kill = snoop_valid && flag && (snoop_blk == blk);
  assign flag_eff   = flag && !snoop_kill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      blk  <= '0;
    end else begin
      if (lr_fire) begin
        flag <= 1'b1;
        blk  <= lr_addr[AW-1:GRAN_LG2];
      end else if (sc_fire || snoop_kill) begin
        flag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/resv_sc_decide.sv
module resv_sc_decide
  import resv_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int GRAN_LG2    = 5,
  parameter bit MISMATCH_OK = 1'b0,
  localparam int BLK_W      = AW - GRAN_LG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sc_fire,
  input  logic [AW-1:0]    ea,
  input  logic [DW-1:0]    data,
  input  logic             so,
  input  logic             flag_eff,
  input  logic [BLK_W-1:0] blk,
  output sc_outcome_e      outcome,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [DW-1:0]    wr_data,
  output logic             cr_valid,
  output logic [3:0]       cr_field
);

  logic same_blk;
  assign same_blk = (ea[AW-1:GRAN_LG2] == blk);

  always_comb begin
    if (!sc_fire)
      outcome = SC_IDLE;
    else if (flag_eff && (same_blk || MISMATCH_OK))
      outcome = SC_STORE;
    else
      outcome = SC_FAIL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      cr_valid <= 1'b0;
      cr_field <= '0;
    end else begin
      wr_en    <= (outcome == SC_STORE);
      cr_valid <= sc_fire;
      if (sc_fire) begin
        wr_addr  <= ea;
        wr_data  <= data;
        cr_field <= cr_pack(outcome == SC_STORE, so);
      end
    end
  end

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int SEL_W       = 5,
  parameter int GRAN_LG2    = 5,
  parameter bit MISMATCH_OK = 1'b0,
  localparam int BLK_W      = AW - GRAN_LG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lr_req,
  input  logic             sc_req,
  input  logic [SEL_W-1:0] ra_sel,
  input  logic [AW-1:0]    ra_val,
  input  logic [AW-1:0]    rb_val,
  input  logic [DW-1:0]    rs_data,
  input  logic             so_in,
  input  logic             snoop_valid,
  input  logic [AW-1:0]    snoop_addr,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [DW-1:0]    wr_data,
  output logic             cr_valid,
  output logic [3:0]       cr_field
);

  logic [AW-1:0]    ea;
  logic             lr_fire;
  logic             resv_flag;
  logic [BLK_W-1:0] resv_blk;
  logic             snoop_kill;
  logic             flag_eff;
  sc_outcome_e      sc_outcome;

  // a store-conditional in the same cycle wins over a load-and-reserve (R11)
  assign lr_fire = lr_req && !sc_req;

  resv_agen #(.AW(AW), .SEL_W(SEL_W)) u_agen (
    .sel   (ra_sel),
    .base  (ra_val),
    .index (rb_val),
    .ea    (ea)
  );

  resv_track #(.AW(AW), .GRAN_LG2(GRAN_LG2)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .lr_fire     (lr_fire),
    .sc_fire     (sc_req),
    .lr_addr     (ea),
    .snoop_valid (snoop_valid),
    .snoop_addr  (snoop_addr),
    .flag        (resv_flag),
    .blk         (resv_blk),
    .snoop_kill  (snoop_kill),
    .flag_eff    (flag_eff)
  );

  resv_sc_decide #(
    .AW(AW), .DW(DW), .GRAN_LG2(GRAN_LG2), .MISMATCH_OK(MISMATCH_OK)
  ) u_decide (
    .clk      (clk),
    .rst_n    (rst_n),
    .sc_fire  (sc_req),
    .ea       (ea),
    .data     (rs_data),
    .so       (so_in),
    .flag_eff (flag_eff),
    .blk      (resv_blk),
    .outcome  (sc_outcome),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cr_valid (cr_valid),
    .cr_field (cr_field)
  );

endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lr_req,
  input logic       sc_req,
  input logic       so_in,
  input logic       wr_en,
  input logic       cr_valid,
  input logic [3:0] cr_field,
  input logic       resv_flag,
  input logic       snoop_kill
);

  a_r3_lr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    lr_req && !sc_req |=> resv_flag);

  a_r3_nibble_top: assert property (@(posedge clk) disable iff (!rst_n)
    cr_valid |-> cr_field[3:2] == 2'b00);

  a_r4_no_resv_fails: assert property (@(posedge clk) disable iff (!rst_n)
    sc_req && !resv_flag |=> !wr_en && !cr_field[1]);

  a_r4_so_copied: assert property (@(posedge clk) disable iff (!rst_n)
    sc_req |=> cr_field[0] == $past(so_in));

  a_r5_sc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sc_req |=> !resv_flag);

  a_r7_kill_clears: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_kill && !lr_req |=> !resv_flag);

  a_r8_kill_beats_sc: assert property (@(posedge clk) disable iff (!rst_n)
    sc_req && snoop_kill |=> !wr_en && !cr_field[1]);

  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sc_req |=> cr_valid);

  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !sc_req |=> !cr_valid && !wr_en);

  a_r10_wr_success: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> cr_valid && cr_field[1]);

endmodule

bind resv_monitor resv_monitor_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lr_req     (lr_req),
  .sc_req     (sc_req),
  .so_in      (so_in),
  .wr_en      (wr_en),
  .cr_valid   (cr_valid),
  .cr_field   (cr_field),
  .resv_flag  (resv_flag),
  .snoop_kill (snoop_kill)
);

// File: tb/resv_monitor_bench.sv
module resv_monitor_bench;

  typedef struct {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  cr;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lr_req = 1'b0, sc_req = 1'b0;
  logic [4:0]  ra_sel = '0;
  logic [31:0] ra_val = '0, rb_val = '0, rs_data = '0;
  logic        so_in = 1'b0;
  logic        snoop_valid = 1'b0;
  logic [31:0] snoop_addr = '0;
  logic        wr_en, cr_valid;
  logic [31:0] wr_addr, wr_data;
  logic [3:0]  cr_field;

  int   n_tests = 0;
  int   n_fail  = 0;
  exp_t sb_q[$];

  logic        m_flag = 1'b0;
  logic [26:0] m_blk  = '0;

  always #2 clk = ~clk;

  resv_monitor u_resv_monitor (
    .clk(clk), .rst_n(rst_n), .lr_req(lr_req), .sc_req(sc_req),
    .ra_sel(ra_sel), .ra_val(ra_val), .rb_val(rb_val), .rs_data(rs_data),
    .so_in(so_in), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cr_valid(cr_valid), .cr_field(cr_field)
  );

  // Driver: one cycle of stimulus, with the bench's own reservation model.
  task automatic cyc(input logic lr, input logic sc, input logic [4:0] sel,
                     input logic [31:0] a, input logic [31:0] b,
                     input logic [31:0] d, input logic so,
                     input logic snv, input logic [31:0] sna, input string req);
    logic [31:0] ea;
    logic        kill, ok;
    exp_t        e;
    @(negedge clk);
    lr_req = lr; sc_req = sc; ra_sel = sel; ra_val = a; rb_val = b;
    rs_data = d; so_in = so; snoop_valid = snv; snoop_addr = sna;
    ea   = ((sel == 5'd0) ? 32'd0 : a) + b;
    kill = snv && m_flag && (sna[31:5] == m_blk);
    if (sc) begin
      ok = m_flag && !kill && (ea[31:5] == m_blk);
      e.wr = ok; e.addr = ea; e.data = d; e.cr = {2'b00, ok, so}; e.req = req;
      sb_q.push_back(e);
      m_flag = 1'b0;
    end else if (lr) begin
      m_flag = 1'b1;
      m_blk  = ea[31:5];
    end else if (kill) begin
      m_flag = 1'b0;
    end
    @(posedge clk);
    #1;
    lr_req = 1'b0; sc_req = 1'b0; snoop_valid = 1'b0;
  endtask

  task automatic lr_op(input logic [4:0] sel, input logic [31:0] a, input logic [31:0] b);
    cyc(1'b1, 1'b0, sel, a, b, 32'd0, 1'b0, 1'b0, 32'd0, "LR");
  endtask

  task automatic sc_op(input logic [4:0] sel, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] d, input logic so, input string req);
    cyc(1'b0, 1'b1, sel, a, b, d, so, 1'b0, 32'd0, req);
  endtask

  task automatic snoop_op(input logic [31:0] sna);
    cyc(1'b0, 1'b0, 5'd0, 32'd0, 32'd0, 32'd0, 1'b0, 1'b1, sna, "SNOOP");
  endtask

  // Monitor: compares results with the scoreboard away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (cr_valid) begin
        n_tests++;
        if (sb_q.size() == 0) begin
          n_fail++;
          $display("FAIL R10: result with no request, got cr=%b wr=%b, expected none",
                   cr_field, wr_en);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          if (wr_en !== e.wr || cr_field !== e.cr ||
              (e.wr && (wr_addr !== e.addr || wr_data !== e.data))) begin
            n_fail++;
            $display("FAIL %s: got wr=%b addr=%h data=%h cr=%b, expected wr=%b addr=%h data=%h cr=%b",
                     e.req, wr_en, wr_addr, wr_data, cr_field, e.wr, e.addr, e.data, e.cr);
          end
        end
      end else if (wr_en) begin
        n_tests++; n_fail++;
        $display("FAIL R10: wr_en=%b without cr_valid, expected 0", wr_en);
      end
    end
  end

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_tests++;
    if (wr_en !== 1'b0 || cr_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R2: wr_en=%b cr_valid=%b in reset, expected 0 0", wr_en, cr_valid);
    end
    rst_n = 1'b1;
    // R2 / R4: no reservation after reset
    sc_op(5'd3, 32'h1000, 32'h20, 32'hAAAA0001, 1'b1, "R4");
    // R3 / R1: base ignored when selector is 0, same-block store succeeds
    lr_op(5'd0, 32'hFFFF, 32'h2000);
    sc_op(5'd0, 32'h1234, 32'h2004, 32'hDEADBEEF, 1'b0, "R3");
    // R5: the reservation is gone
    sc_op(5'd0, 32'h0, 32'h2004, 32'h11111111, 1'b1, "R5");
    // R6: other block fails and still clears
    lr_op(5'd2, 32'h100, 32'h40);
    sc_op(5'd1, 32'h3000, 32'h0, 32'h22222222, 1'b0, "R6");
    sc_op(5'd2, 32'h100, 32'h40, 32'h33333333, 1'b0, "R6");
    // R7: snoop elsewhere keeps, snoop in block kills
    lr_op(5'd4, 32'h500, 32'h0);
    snoop_op(32'h9000);
    sc_op(5'd4, 32'h500, 32'h1C, 32'h44444444, 1'b1, "R7");
    lr_op(5'd4, 32'h500, 32'h0);
    snoop_op(32'h510);
    sc_op(5'd4, 32'h500, 32'h0, 32'h55555555, 1'b0, "R7");
    // R8: snoop kill and store-conditional in the same cycle
    lr_op(5'd0, 32'h0, 32'h600);
    cyc(1'b0, 1'b1, 5'd0, 32'h0, 32'h600, 32'h66666666, 1'b1, 1'b1, 32'h604, "R8");
    // R9: new reservation replaces the old block
    lr_op(5'd0, 32'h0, 32'h700);
    lr_op(5'd0, 32'h0, 32'h800);
    sc_op(5'd0, 32'h0, 32'h700, 32'h77777777, 1'b0, "R9");
    lr_op(5'd0, 32'h0, 32'h800);
    sc_op(5'd0, 32'h0, 32'h808, 32'h88888888, 1'b1, "R9");
    // R11: a load-and-reserve with a store-conditional is dropped
    cyc(1'b1, 1'b1, 5'd0, 32'h0, 32'hA00, 32'h99999999, 1'b0, 1'b0, 32'h0, "R11");
    sc_op(5'd0, 32'h0, 32'hA00, 32'hAAAAAAAA, 1'b0, "R11");
    // R1 / R10: wrap-around sum, back-to-back requests
    lr_op(5'd7, 32'hFFFFFFF0, 32'h20);
    sc_op(5'd7, 32'hFFFFFFF0, 32'h24, 32'hBBBBBBBB, 1'b1, "R1");
    sc_op(5'd7, 32'hFFFFFFF0, 32'h24, 32'hCCCCCCCC, 1'b0, "R10");
    repeat (4) @(posedge clk);
    @(negedge clk);
    n_tests++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R10: %0d results missing, expected 0", sb_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule